// File: doc/BRIEF.md
# Programmable Chip Select Decoder

This block turns each bus address into active-low chip selects for one bus cycle. A peripheral block of seven 256-byte regions sits at a programmable base. That block lives in either I/O or memory space. A midrange memory block of programmable base and power-of-two size is split into quarters. The first three quarters each drive a midrange select, and the fourth drives nothing. Selects are captured on the clock edge that samples the address-phase strobe, so they are valid during the multiplexed address phase. They are released on the edge that samples the end of the bus cycle.

Two peripheral select pins can carry latched address bits 1 and 2 instead of a select. Those latched bits keep their value while the bus is held. Bus hold and reset force every select inactive. A small write port loads two configuration words, and a write takes effect at the next address phase.

Top module: `chip_sel_decoder`

## Requirements
- R1: With word 0 bit 15 set, peripheral select n (pcs_n_o[n]) is driven low for an address in base + n*256 .. base + n*256 + 255. The base is word 0 bits [8:0] shifted left by 11.
- R2: Word 0 bit 14 picks the peripheral space: 1 means I/O cycles (io_space_i=1), 0 means memory cycles. An access in the other space drives no peripheral select.
- R3: Region index 4 and the region past index 6 never drive any select. An address outside every enabled region drives no select.
- R4: With word 1 bit 15 set, the midrange block is 8 KB shifted left by word 1 bits [10:8]. Codes above 6 act as 512 KB. The base is word 1 bits [6:0] shifted left by 13, aligned to the size. Select k (mcs_n_o[k]) covers quarter k, the fourth quarter drives none, and only memory cycles (io_space_i=0) match.
- R5: Outputs take the decode on the edge that samples ale_i high. They hold it until the edge that samples cycle_end_i high with ale_i low, and then all selects go high.
- R6: While hold_i is high, all selects are high at once, and ale_i is ignored. A select that was active stays released after hold ends.
- R7: After reset, all outputs are high, both blocks are disabled, and the select mode (word 0 bit 13 = 1) is active.
- R8: With word 0 bit 13 = 0, pcs_n_o[5] carries address bit 1 and pcs_n_o[6] carries address bit 2. Both bits are latched on an edge that samples ale_i high with hold_i low.
- R9: While hold_i is high, the latched address bits on pcs_n_o[6:5] do not change.
- R10: A configuration write (cfg_we_i, with cfg_sel_i 0 for word 0 and 1 for word 1) made during an active cycle leaves the current outputs unchanged. The next address phase decodes with the new value.
- R11: At most one peripheral select and at most one midrange select are low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 20 | Bus address in the address phase |
| io_space_i | input | 1 | 1 for an I/O cycle, 0 for a memory cycle |
| ale_i | input | 1 | Address-phase strobe |
| cycle_end_i | input | 1 | End of the current bus cycle |
| hold_i | input | 1 | Bus hold in effect |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_sel_i | input | 1 | Configuration word select (0 peripheral, 1 midrange) |
| cfg_wdata_i | input | 16 | Configuration write data |
| pcs_n_o | output | 7 | Peripheral selects, active low; bits 5 and 6 may carry address bits |
| mcs_n_o | output | 3 | Midrange selects, active low |

## Verification
The bench builds the block with its default parameters: a 20-bit address, seven 256-byte peripheral regions and an 8 KB minimum midrange granule. With these values every region edge, the unused index 4 and the index-7 gap can be reached. Every midrange size code can be reached as well, including the smallest 8 KB block and the clamped codes above 512 KB. The full-width address makes the large-block alignment and the wrong-space cases directly checkable.

// File: rtl/chip_sel_pkg.sv
package chip_sel_pkg;
  typedef enum logic {CFG_PCS = 1'b0, CFG_MCS = 1'b1} cfg_sel_e;
  localparam int unsigned EN_BIT   = 15;
  localparam int unsigned IO_BIT   = 14;
  localparam int unsigned EX_BIT   = 13;
  localparam int unsigned CODE_LSB = 8;
  localparam int unsigned CODE_W   = 3;
  localparam int unsigned MAX_CODE = 6;
endpackage

// File: rtl/chip_sel_cfg.sv
module chip_sel_cfg
  import chip_sel_pkg::*;
#(
  parameter int unsigned PB_W = 9,
  parameter int unsigned MB_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              sel_i,
  input  logic [15:0]       wdata_i,
  output logic              pcs_en_o,
  output logic              pcs_io_o,
  output logic              ex_o,
  output logic [PB_W-1:0]   pcs_base_o,
  output logic              mcs_en_o,
  output logic [CODE_W-1:0] mcs_code_o,
  output logic [MB_W-1:0]   mcs_base_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcs_en_o   <= 1'b0;
      pcs_io_o   <= 1'b0;
      ex_o       <= 1'b1;
      pcs_base_o <= '0;
      mcs_en_o   <= 1'b0;
      mcs_code_o <= '0;
      mcs_base_o <= '0;
    end else if (we_i) begin
      if (cfg_sel_e'(sel_i) == CFG_PCS) begin
        pcs_en_o   <= wdata_i[EN_BIT];
        pcs_io_o   <= wdata_i[IO_BIT];
        ex_o       <= wdata_i[EX_BIT];
        pcs_base_o <= wdata_i[PB_W-1:0];
      end else begin
        mcs_en_o   <= wdata_i[EN_BIT];
        mcs_code_o <= wdata_i[CODE_LSB +: CODE_W];
        mcs_base_o <= wdata_i[MB_W-1:0];
      end
    end
  end
endmodule

// File: rtl/chip_sel_pcs_dec.sv
module chip_sel_pcs_dec #(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned N_PCS   = 7,
  parameter int unsigned REGN_LG = 8,
  parameter int unsigned SKIP_IX = 4,
  localparam int unsigned IDX_W  = $clog2(N_PCS),
  localparam int unsigned PB_W   = ADDR_W - REGN_LG - IDX_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              io_i,
  input  logic              en_i,
  input  logic              space_io_i,
  input  logic [PB_W-1:0]   base_i,
  output logic [N_PCS-1:0]  hit_o
);
  logic             blk_hit;
  logic [IDX_W-1:0] idx;

  assign blk_hit = en_i && (io_i == space_io_i) &&
                   (addr_i[ADDR_W-1 -: PB_W] == base_i);
  assign idx     = addr_i[REGN_LG +: IDX_W];

  for (genvar n = 0; n < N_PCS; n++) begin : g_sel
    if (n == SKIP_IX) begin : g_skip
      assign hit_o[n] = 1'b0;
    end else begin : g_use
      assign hit_o[n] = blk_hit && (idx == IDX_W'(n));
    end
  end
endmodule

// File: rtl/chip_sel_mcs_dec.sv
module chip_sel_mcs_dec
  import chip_sel_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned MIN_LG = 13,
  parameter int unsigned N_MCS  = 3,
  localparam int unsigned MB_W  = ADDR_W - MIN_LG
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              io_i,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [MB_W-1:0]   base_i,
  output logic [N_MCS-1:0]  hit_o
);
  logic [CODE_W-1:0] code_c;
  logic [MB_W-1:0]   mask;
  logic [ADDR_W-1:0] qtr;
  logic              blk_hit;

  always_comb begin
    code_c  = (code_i > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code_i;
    mask    = {MB_W{1'b1}} << code_c;
    qtr     = addr_i >> (MIN_LG - 2 + int'(code_c));
    blk_hit = en_i && !io_i &&
              (((addr_i[ADDR_W-1 -: MB_W] ^ base_i) & mask) == '0);
    for (int k = 0; k < N_MCS; k++)
      hit_o[k] = blk_hit && (qtr[1:0] == 2'(k));
  end
endmodule

// File: rtl/chip_sel_decoder.sv
module chip_sel_decoder
  import chip_sel_pkg::*;
#(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned N_PCS   = 7,
  parameter int unsigned N_MCS   = 3,
  parameter int unsigned REGN_LG = 8,
  parameter int unsigned MIN_LG  = 13,
  localparam int unsigned PB_W   = ADDR_W - REGN_LG - $clog2(N_PCS),
  localparam int unsigned MB_W   = ADDR_W - MIN_LG,
  localparam int unsigned A1_PIN = N_PCS - 2,
  localparam int unsigned A2_PIN = N_PCS - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              io_space_i,
  input  logic              ale_i,
  input  logic              cycle_end_i,
  input  logic              hold_i,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [15:0]       cfg_wdata_i,
  output logic [N_PCS-1:0]  pcs_n_o,
  output logic [N_MCS-1:0]  mcs_n_o
);
  logic              pcs_en, pcs_io, ex_q, mcs_en;
  logic [PB_W-1:0]   pcs_base;
  logic [CODE_W-1:0] mcs_code;
  logic [MB_W-1:0]   mcs_base;
  logic [N_PCS-1:0]  pcs_hit, pcs_q, pcs_sel_n;
  logic [N_MCS-1:0]  mcs_hit, mcs_q;
  logic [1:0]        abit_q;

  chip_sel_cfg #(.PB_W(PB_W), .MB_W(MB_W)) u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
    .pcs_en_o(pcs_en), .pcs_io_o(pcs_io), .ex_o(ex_q), .pcs_base_o(pcs_base),
    .mcs_en_o(mcs_en), .mcs_code_o(mcs_code), .mcs_base_o(mcs_base)
  );

  chip_sel_pcs_dec #(.ADDR_W(ADDR_W), .N_PCS(N_PCS), .REGN_LG(REGN_LG)) u_pcs (
    .addr_i, .io_i(io_space_i), .en_i(pcs_en), .space_io_i(pcs_io),
    .base_i(pcs_base), .hit_o(pcs_hit)
  );

  chip_sel_mcs_dec #(.ADDR_W(ADDR_W), .MIN_LG(MIN_LG), .N_MCS(N_MCS)) u_mcs (
    .addr_i, .io_i(io_space_i), .en_i(mcs_en), .code_i(mcs_code),
    .base_i(mcs_base), .hit_o(mcs_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcs_q <= '0;
      mcs_q <= '0;
    end else if (hold_i) begin
      pcs_q <= '0;
      mcs_q <= '0;
    end else if (ale_i) begin
      pcs_q <= pcs_hit;
      mcs_q <= mcs_hit;
    end else if (cycle_end_i) begin
      pcs_q <= '0;
      mcs_q <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                abit_q <= '0;
    else if (ale_i && !hold_i)  abit_q <= addr_i[2:1];
  end

  // hold gates the selects at once; latched address pins are not gated
  assign pcs_sel_n = ~pcs_q | {N_PCS{hold_i}};
  assign mcs_n_o   = ~mcs_q | {N_MCS{hold_i}};

  always_comb begin
    pcs_n_o = pcs_sel_n;
    if (!ex_q) begin
      pcs_n_o[A1_PIN] = abit_q[0];
      pcs_n_o[A2_PIN] = abit_q[1];
    end
  end
endmodule

// File: rtl/chip_sel_decoder_chk.sv
module chip_sel_decoder_chk #(
  parameter int unsigned N_PCS = 7,
  parameter int unsigned N_MCS = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ale_i,
  input logic             cycle_end_i,
  input logic             hold_i,
  input logic             ex_i,
  input logic [N_PCS-1:0] pcs_n_i,
  input logic [N_MCS-1:0] mcs_n_i
);
  p_mcs_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ale_i && cycle_end_i) |=> (&mcs_n_i));

  p_pcs_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ale_i && cycle_end_i && ex_i) |=> (!ex_i || (&pcs_n_i)));

  p_hold_mcs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |-> (&mcs_n_i));

  p_hold_pcs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && ex_i) |-> (&pcs_n_i));

  p_abit_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(hold_i) && !ex_i && $stable(ex_i)) |-> $stable(pcs_n_i[N_PCS-1 -: 2]));

  p_mcs_onehot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~mcs_n_i));

  p_pcs_onehot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_i |-> $onehot0(~pcs_n_i));
endmodule

bind chip_sel_decoder chip_sel_decoder_chk #(.N_PCS(N_PCS), .N_MCS(N_MCS)) u_chk (
  .clk_i, .rst_ni, .ale_i, .cycle_end_i, .hold_i, .ex_i(ex_q),
  .pcs_n_i(pcs_n_o), .mcs_n_i(mcs_n_o)
);

// File: tb/chip_sel_decoder_tb.sv
`timescale 1ns/1ps
module chip_sel_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] addr = '0;
  logic        io = 1'b0, ale = 1'b0, cend = 1'b0, hold = 1'b0;
  logic        we = 1'b0, wsel = 1'b0;
  logic [15:0] wdata = '0;
  logic [6:0]  pcs_n;
  logic [2:0]  mcs_n;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  chip_sel_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .io_space_i(io), .ale_i(ale),
    .cycle_end_i(cend), .hold_i(hold), .cfg_we_i(we), .cfg_sel_i(wsel),
    .cfg_wdata_i(wdata), .pcs_n_o(pcs_n), .mcs_n_o(mcs_n)
  );

  // {io, addr, expected pcs_n, expected mcs_n}; peripheral base 0x10000 mem, midrange 64 KB at 0x40000
  localparam int NV = 15;
  localparam logic [30:0] VEC [NV] = '{
    {1'b0, 20'h10000, 7'b1111110, 3'b111},
    {1'b0, 20'h101FF, 7'b1111101, 3'b111},
    {1'b0, 20'h10300, 7'b1110111, 3'b111},
    {1'b0, 20'h10400, 7'b1111111, 3'b111},
    {1'b0, 20'h105AB, 7'b1011111, 3'b111},
    {1'b0, 20'h106FF, 7'b0111111, 3'b111},
    {1'b0, 20'h10700, 7'b1111111, 3'b111},
    {1'b0, 20'h0FFFF, 7'b1111111, 3'b111},
    {1'b0, 20'h40000, 7'b1111111, 3'b110},
    {1'b0, 20'h44000, 7'b1111111, 3'b101},
    {1'b0, 20'h4BFFF, 7'b1111111, 3'b011},
    {1'b0, 20'h4C000, 7'b1111111, 3'b111},
    {1'b0, 20'h50000, 7'b1111111, 3'b111},
    {1'b1, 20'h10000, 7'b1111111, 3'b111},
    {1'b1, 20'h40000, 7'b1111111, 3'b111}
  };

  task automatic chk(string req, logic [6:0] ep, logic [2:0] em);
    checks++;
    if (pcs_n !== ep || mcs_n !== em) begin
      fails++;
      $display("FAIL %s pcs_n=%b mcs_n=%b expected pcs_n=%b mcs_n=%b", req, pcs_n, mcs_n, ep, em);
    end
  endtask

  task automatic wr(logic s, logic [15:0] d);
    @(negedge clk); we = 1'b1; wsel = s; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic start(logic i, logic [19:0] a);
    @(negedge clk); io = i; addr = a; ale = 1'b1;
    @(negedge clk); ale = 1'b0;
  endtask

  task automatic finish_cyc();
    @(negedge clk); cend = 1'b1;
    @(negedge clk); cend = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    #5; rst_n = 1'b1;
    @(negedge clk);
    chk("R7 reset idle", 7'h7F, 3'h7);
    start(1'b0, 20'h00000);
    chk("R7 disabled after reset", 7'h7F, 3'h7);
    finish_cyc();

    wr(1'b0, 16'hA020);
    wr(1'b1, 16'h8320);
    for (int v = 0; v < NV; v++) begin
      start(VEC[v][30], VEC[v][29:10]);
      chk($sformatf("R1/R2/R3/R4 vector %0d", v), VEC[v][9:3], VEC[v][2:0]);
      finish_cyc();
      chk("R5 release", 7'h7F, 3'h7);
    end

    // R5: selects hold across idle cycles until cycle end
    start(1'b0, 20'h10100);
    @(negedge clk); @(negedge clk);
    chk("R5 held", 7'b1111101, 3'h7);
    finish_cyc();

    // R10: config change mid-cycle
    start(1'b0, 20'h10000);
    wr(1'b0, 16'hA021);
    chk("R10 active unchanged", 7'b1111110, 3'h7);
    finish_cyc();
    start(1'b0, 20'h10000);
    chk("R10 old base gone", 7'h7F, 3'h7);
    finish_cyc();
    start(1'b0, 20'h10800);
    chk("R10 new base", 7'b1111110, 3'h7);
    finish_cyc();

    // R2: I/O space
    wr(1'b0, 16'hE020);
    start(1'b1, 20'h10200);
    chk("R2 io match", 7'b1111011, 3'h7);
    finish_cyc();
    start(1'b0, 20'h10200);
    chk("R2 mem ignored", 7'h7F, 3'h7);
    finish_cyc();
    wr(1'b0, 16'hA020);

    // R4: largest and clamped sizes, smallest size
    wr(1'b1, 16'h8640);
    start(1'b0, 20'hA0000);
    chk("R4 512K q1", 7'h7F, 3'b101);
    finish_cyc();
    wr(1'b1, 16'h8740);
    start(1'b0, 20'hC0000);
    chk("R4 clamp q2", 7'h7F, 3'b011);
    finish_cyc();
    start(1'b0, 20'hE0000);
    chk("R4 clamp q3 none", 7'h7F, 3'h7);
    finish_cyc();
    wr(1'b1, 16'h8003);
    start(1'b0, 20'h06800);
    chk("R4 8K q1", 7'h7F, 3'b101);
    finish_cyc();
    wr(1'b1, 16'h0003);
    start(1'b0, 20'h06800);
    chk("R4 disabled", 7'h7F, 3'h7);
    finish_cyc();

    // R6: hold releases active selects at once
    wr(1'b1, 16'h8320);
    start(1'b0, 20'h40000);
    chk("R6 before hold", 7'h7F, 3'b110);
    @(negedge clk); hold = 1'b1;
    #0.5;
    chk("R6 hold forces high", 7'h7F, 3'h7);
    @(negedge clk); io = 1'b0; addr = 20'h10000; ale = 1'b1;
    @(negedge clk); ale = 1'b0;
    chk("R6 ale ignored in hold", 7'h7F, 3'h7);
    hold = 1'b0;
    @(negedge clk);
    chk("R6 stays released", 7'h7F, 3'h7);
    finish_cyc();

    // R8/R9: latched address bits
    wr(1'b0, 16'h8020);
    start(1'b0, 20'h10002);
    chk("R8 abits", 7'b0111110, 3'h7);
    finish_cyc();
    chk("R8 abits after end", 7'b0111111, 3'h7);
    @(negedge clk); hold = 1'b1;
    @(negedge clk); addr = 20'h10004; ale = 1'b1;
    @(negedge clk); ale = 1'b0;
    chk("R9 abits kept in hold", 7'b0111111, 3'h7);
    hold = 1'b0;
    @(negedge clk);
    chk("R9 abits after hold", 7'b0111111, 3'h7);
    start(1'b0, 20'h10104);
    chk("R8 abits reload", 7'b1011101, 3'h7);
    finish_cyc();

    done = 1;
    summary();
  end
endmodule